// File: doc/BRIEF.md
# Packed Quadword-to-Word Narrowing Unit

This block narrows packed 64-bit integer lanes of a vector operand into packed 16-bit words. Each narrowed word is produced in one of three ways, chosen by an opcode byte: plain truncation, clamping as a signed value, or clamping as an unsigned value. A length select picks how many source lanes take part (2, 4 or 8). The narrowed words are placed side by side from the bottom of a 128-bit result, and everything above them is cleared.

A per-lane write enable decides which result words take the narrowed value. A disabled word either keeps the word from the prior destination or is cleared, depending on a zeroing control. The block checks a 4-bit reserved operand field and the opcode byte. If either is unrecognised, it raises an undefined-operation flag and returns the prior destination unchanged. All outputs are registered, so a result appears one cycle after its input strobe.

Top module: `qw_narrow`

## Requirements
- R1: The length select sets the active lane count: `vlen_sel` 2'b00 gives 2 lanes, 2'b01 gives 4 lanes, and 2'b10 or 2'b11 gives 8 lanes.
- R2: Source lane i (bits 64*i+63 down to 64*i of `src`) produces result word i (bits 16*i+15 down to 16*i of `dst_out`).
- R3: Opcode 8'h34 selects truncation, and each word is the low 16 bits of its lane.
- R4: Opcode 8'h24 selects signed clamping. A lane above 32767 gives 16'h7FFF, a lane below -32768 gives 16'h8000, and any other lane gives its low 16 bits.
- R5: Opcode 8'h14 selects unsigned clamping. A lane above 65535 gives 16'hFFFF, and any other lane gives its low 16 bits.
- R6: An active word whose `wmask` bit is clear keeps the matching word of `dst_prev` when `zero_en` is 0.
- R7: An active word whose `wmask` bit is clear becomes zero when `zero_en` is 1.
- R8: Result bits above 16 times the active lane count are zero.
- R9: A `rsvd` value other than 4'b1111 sets `undef_op` and makes `dst_out` equal to `dst_prev`.
- R10: An opcode other than 8'h34, 8'h24 or 8'h14 sets `undef_op` and makes `dst_out` equal to `dst_prev`.
- R11: `wmask` bits at positions at or above the active lane count have no effect on `dst_out`.
- R12: `out_valid`, `dst_out` and `undef_op` reflect an input presented with `in_valid` exactly one clock later, and `out_valid` is low in a cycle that follows no strobe.
- R13: A synchronous active-high `rst` clears `out_valid` and `undef_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| src | input | 512 | Packed 64-bit source lanes |
| vlen_sel | input | 2 | Active lane count select |
| op_code | input | 8 | Narrowing mode opcode |
| wmask | input | 8 | Per-lane write enable |
| zero_en | input | 1 | 1 clears disabled words, 0 keeps prior words |
| dst_prev | input | 128 | Prior destination value |
| rsvd | input | 4 | Reserved operand field, must be 4'b1111 |
| out_valid | output | 1 | Result strobe |
| dst_out | output | 128 | Narrowed result |
| undef_op | output | 1 | Undefined-operation flag |

## Verification
The bench builds the block with its default parameters: eight 64-bit lanes narrowed to 16-bit words. This puts every lane count (2, 4 and 8) within reach, along with the exact clamping thresholds at 32767, 32768, -32768, -32769, 65535 and 65536. It also makes mask bits above a short vector available to prove that they are ignored. Back-to-back strobes and idle gaps exercise the one-cycle alignment of the result with its input.

// File: rtl/qw_narrow.sv
module qw_narrow #(
  parameter int LANES = 8,
  parameter int SRC_W = 64,
  parameter int DST_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [LANES*SRC_W-1:0]   src,
  input  logic [1:0]               vlen_sel,
  input  logic [7:0]               op_code,
  input  logic [LANES-1:0]         wmask,
  input  logic                     zero_en,
  input  logic [LANES*DST_W-1:0]   dst_prev,
  input  logic [3:0]               rsvd,
  output logic                     out_valid,
  output logic [LANES*DST_W-1:0]   dst_out,
  output logic                     undef_op
);
  localparam int OUT_W = LANES * DST_W;
  localparam int CNT_W = $clog2(LANES) + 2;
  localparam logic [7:0] OP_TRUNC = 8'h34;
  localparam logic [7:0] OP_SSAT  = 8'h24;
  localparam logic [7:0] OP_USAT  = 8'h14;

  logic [CNT_W-1:0] act_n;
  logic             bad;
  logic [OUT_W-1:0] res;

  assign act_n = (vlen_sel[1]) ? CNT_W'(LANES) :
                 (vlen_sel[0]) ? CNT_W'(LANES >> 1) : CNT_W'(LANES >> 2);
  assign bad   = (rsvd != 4'b1111) ||
                 !(op_code == OP_TRUNC || op_code == OP_SSAT || op_code == OP_USAT);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SRC_W-1:0] elem;
    logic [DST_W-1:0] nar, prv;
    logic             s_fit, u_over, on;
    assign elem   = src[i*SRC_W +: SRC_W];
    assign prv    = dst_prev[i*DST_W +: DST_W];
    assign s_fit  = (&elem[SRC_W-1:DST_W-1]) || !(|elem[SRC_W-1:DST_W-1]);
    assign u_over = |elem[SRC_W-1:DST_W];
    assign on     = CNT_W'(i) < act_n;
    always_comb begin
      nar = elem[DST_W-1:0];
      if (op_code == OP_SSAT && !s_fit)
        nar = elem[SRC_W-1] ? {1'b1, {(DST_W-1){1'b0}}} : {1'b0, {(DST_W-1){1'b1}}};
      else if (op_code == OP_USAT && u_over)
        nar = '1;
    end
    assign res[i*DST_W +: DST_W] = !on ? '0 : wmask[i] ? nar : zero_en ? '0 : prv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      undef_op  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        undef_op <= bad;
        dst_out  <= bad ? dst_prev : res;
      end
    end
  end

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_rsvd_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rsvd != 4'b1111) |=> (undef_op && dst_out == $past(dst_prev)));
  assert_short_upper_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vlen_sel == 2'b00 && rsvd == 4'b1111) |=> (undef_op || dst_out[OUT_W-1:OUT_W/4] == '0));
  assert_reset_clears_R13: assert property (@(posedge clk)
    rst |=> (!out_valid && !undef_op));
endmodule

// File: tb/test_qw_narrow.sv
module test_qw_narrow;
  logic         clk = 0;
  logic         rst = 1;
  logic         in_valid = 0;
  logic [511:0] src = '0;
  logic [1:0]   vlen_sel = 0;
  logic [7:0]   op_code = 8'h34;
  logic [7:0]   wmask = 0;
  logic         zero_en = 0;
  logic [127:0] dst_prev = '0;
  logic [3:0]   rsvd = 4'hF;
  logic         out_valid, undef_op;
  logic [127:0] dst_out;

  int applied = 0, errs = 0;
  logic [127:0] q_d[$];
  logic         q_u[$];
  string        q_t[$];
  bit           done = 0;

  always #5 clk = ~clk;

  qw_narrow i_qw_narrow (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .vlen_sel(vlen_sel),
    .op_code(op_code), .wmask(wmask), .zero_en(zero_en), .dst_prev(dst_prev),
    .rsvd(rsvd), .out_valid(out_valid), .dst_out(dst_out), .undef_op(undef_op));

  function automatic logic [511:0] mk(input logic [63:0] a0, a1, a2, a3, a4, a5, a6, a7);
    return {a7, a6, a5, a4, a3, a2, a1, a0};
  endfunction

  function automatic void model(input logic [511:0] s, input logic [1:0] vs,
      input logic [7:0] op, input logic [7:0] m, input logic z,
      input logic [127:0] p, input logic [3:0] r,
      output logic [127:0] d, output logic u);
    int n;
    n = (vs == 2'b00) ? 2 : (vs == 2'b01) ? 4 : 8;
    u = (r != 4'hF) || !(op == 8'h34 || op == 8'h24 || op == 8'h14);
    d = '0;
    if (u) begin d = p; return; end
    for (int k = 0; k < n; k++) begin
      logic [63:0] e;
      logic [15:0] w;
      e = s[k*64 +: 64];
      w = e[15:0];
      if (op == 8'h24) begin
        if ($signed(e) > 64'sd32767) w = 16'h7FFF;
        else if ($signed(e) < -64'sd32768) w = 16'h8000;
      end else if (op == 8'h14) begin
        if (e > 64'd65535) w = 16'hFFFF;
      end
      if (m[k]) d[k*16 +: 16] = w;
      else if (!z) d[k*16 +: 16] = p[k*16 +: 16];
    end
  endfunction

  task automatic drive(input string tag, input logic [511:0] s, input logic [1:0] vs,
      input logic [7:0] op, input logic [7:0] m, input logic z,
      input logic [127:0] p, input logic [3:0] r);
    logic [127:0] d;
    logic u;
    @(negedge clk);
    src = s; vlen_sel = vs; op_code = op; wmask = m; zero_en = z; dst_prev = p; rsvd = r;
    in_valid = 1;
    model(s, vs, op, m, z, p, r, d, u);
    q_d.push_back(d); q_u.push_back(u); q_t.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0;
      src = {16{32'hDEADBEEF}};
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      if (out_valid && q_d.size() == 0) begin
        errs++; applied++;
        $display("FAIL R12: out_valid act=1 exp=0");
      end else if (!out_valid && q_d.size() != 0) begin
        errs++; applied++;
        $display("FAIL R12: out_valid act=0 exp=1 (%s)", q_t[0]);
        void'(q_d.pop_front()); void'(q_u.pop_front()); void'(q_t.pop_front());
      end else if (out_valid) begin
        logic [127:0] ed; logic eu; string t;
        ed = q_d.pop_front(); eu = q_u.pop_front(); t = q_t.pop_front();
        applied++;
        if (dst_out !== ed || undef_op !== eu) begin
          errs++;
          $display("FAIL %s: act dst=%h undef=%b exp dst=%h undef=%b", t, dst_out, undef_op, ed, eu);
        end
      end
    end
  end

  initial begin
    logic [127:0] pv;
    logic [511:0] s;
    pv = 128'hA1A1_B2B2_C3C3_D4D4_E5E5_F6F6_0707_1818;
    repeat (3) @(negedge clk);
    applied++;
    if (out_valid !== 1'b0 || undef_op !== 1'b0) begin
      errs++;
      $display("FAIL R13: act valid=%b undef=%b exp 0 0", out_valid, undef_op);
    end
    rst = 0;
    s = mk(64'h1111_2222_3333_0001, 64'hFFFF_FFFF_FFFF_8002, 64'h0000_0001_0000_0003,
           64'h7FFF_FFFF_FFFF_0004, 64'h8000_0000_0000_0005, 64'h0000_0000_0000_ABCD,
           64'h1234_5678_9ABC_0007, 64'h0000_0000_0001_0008);
    drive("R3 R2 trunc 8 lanes", s, 2'b10, 8'h34, 8'hFF, 0, pv, 4'hF);
    drive("R4 signed clamp", mk(64'd32767, 64'd32768, -64'sd32768, -64'sd32769,
          64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, -64'sd1, 64'd5),
          2'b10, 8'h24, 8'hFF, 0, pv, 4'hF);
    drive("R5 unsigned clamp", mk(64'd65535, 64'd65536, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0,
          64'd1234, 64'h0001_0000_0000_0000, 64'd65534, 64'h8000_0000_0000_0000),
          2'b10, 8'h14, 8'hFF, 0, pv, 4'hF);
    idle(2);
    drive("R6 merge", s, 2'b10, 8'h34, 8'b1010_0110, 0, pv, 4'hF);
    drive("R7 zero", s, 2'b10, 8'h24, 8'b1010_0110, 1, pv, 4'hF);
    drive("R1 R8 R11 two lanes", s, 2'b00, 8'h34, 8'hFF, 0, pv, 4'hF);
    drive("R11 two lanes merge", s, 2'b00, 8'h14, 8'hFE, 0, pv, 4'hF);
    drive("R1 R8 four lanes", s, 2'b01, 8'h24, 8'h0F, 0, pv, 4'hF);
    drive("R11 four lanes zero", s, 2'b01, 8'h34, 8'hF5, 1, pv, 4'hF);
    drive("R1 sel 11", s, 2'b11, 8'h14, 8'hFF, 0, pv, 4'hF);
    idle(1);
    drive("R9 rsvd", s, 2'b10, 8'h34, 8'hFF, 0, pv, 4'hE);
    drive("R9 rsvd zero", s, 2'b00, 8'h24, 8'h00, 1, ~pv, 4'h0);
    drive("R10 opcode", s, 2'b10, 8'h35, 8'hFF, 0, pv, 4'hF);
    drive("R10 opcode 04", s, 2'b01, 8'h04, 8'hFF, 1, ~pv, 4'hF);
    drive("R12 recover", s, 2'b01, 8'h14, 8'hFF, 0, pv, 4'hF);
    idle(3);
    done = 1;
    if (q_d.size() != 0) begin
      errs++; applied++;
      $display("FAIL R12: %0d results act missing exp 0", q_d.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, errs);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    done = 1;
    errs++; applied++;
    $display("FAIL watchdog: act hung exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, errs);
    $finish;
  end
endmodule